// File: doc/BRIEF.md
# USB OUT Endpoint Receive Bank Writer

This block sits behind a packet-level receive front end on a USB device endpoint. It takes one OUT data packet at a time as a byte stream. The last beat of the stream also carries the packet's toggle type and a CRC-valid flag. The block writes the bytes into a single endpoint bank whose size is set by a parameter. When the packet ends, it records the number of bytes stored and the toggle type, and it sets sticky status flags for:

- packet received
- short packet
- overflow
- CRC error
- the two high-bandwidth isochronous toggle classes

Each flag has an enable bit, and the interrupt output combines the enabled flags. Software clears a flag by writing one to its clear bit. Software or a test harness reads the bank back through a plain combinational read port.

Stream rules:

- A beat transfers on a rising edge where `s_valid` and `s_ready` are both high.
- `s_ready` is high whenever reset is released, so the block never applies back-pressure. A source may hold `s_valid` low between beats for as long as it likes.
- A beat with `s_keep` low carries no byte. This is how a zero-length packet is sent: one beat with `s_last` high and `s_keep` low.
- `s_pid` and `s_crc_ok` are sampled only on the beat where `s_last` is high.

Configuration pins are static while a packet is in flight. Setting `cfg_hbiso` implies isochronous behaviour. A packet counts as accepted when its CRC is good, or when the endpoint is isochronous.

Top module: `usbw_out_bank_writer`

## Requirements
- R1: After reset, all six flags are zero, `irq` is low, `byte_count` is zero and `last_toggle` reads 2'b01 (Data1).
- R2: Bytes of a packet are written to bank addresses 0, 1, 2, ... in arrival order. Beats with `s_keep` low store nothing. On acceptance, `byte_count` equals the number of bytes stored.
- R3: When a packet is longer than BANK_BYTES, only its first BANK_BYTES bytes are stored. `byte_count` reads BANK_BYTES. The overflow flag (bit 2) and the received flag (bit 0) are both set.
- R4: An accepted packet sets the received flag (bit 0). If the endpoint is not a control endpoint and the packet's received length is below `cfg_max_pkt`, it also sets the short flag (bit 1). A control endpoint never sets the short flag.
- R5: On an isochronous endpoint, a packet with a failed CRC is stored and accepted as normal, and it also sets the CRC-error flag (bit 3).
- R6: On a non-isochronous endpoint, a packet with a failed CRC sets no flag and leaves `byte_count` and `last_toggle` unchanged.
- R7: `last_toggle` holds the toggle type of the last accepted packet, encoded as 2'b00 Data0, 2'b01 Data1, 2'b10 Data2, 2'b11 MData.
- R8: With `cfg_hbiso` high, an accepted MData packet sets flag bit 4 and an accepted Data0/1/2 packet sets flag bit 5. With `cfg_hbiso` low, neither flag is set.
- R9: A flag stays set until a one is written to its bit of `flag_clr`, and a zero leaves it unchanged. When a set and a clear of the same flag meet in one cycle, the set wins.
- R10: `irq` is high exactly when some flag and its bit of `flag_en` are both high.
- R11: `s_ready` is high whenever `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_control | input | 1 | Endpoint is a control endpoint |
| cfg_iso | input | 1 | Endpoint is isochronous |
| cfg_hbiso | input | 1 | High-bandwidth isochronous mode |
| cfg_max_pkt | input | LEN_W | Maximum packet size in bytes |
| s_valid | input | 1 | Beat valid |
| s_ready | output | 1 | Beat accepted when high |
| s_data | input | 8 | Data byte |
| s_keep | input | 1 | Beat carries a byte |
| s_last | input | 1 | Final beat of the packet |
| s_pid | input | 2 | Toggle type, sampled with `s_last` |
| s_crc_ok | input | 1 | CRC good, sampled with `s_last` |
| flag_en | input | 6 | Per-flag interrupt enables |
| flag_clr | input | 6 | Write-one-to-clear strobes |
| flags | output | 6 | Sticky flags: 0 received, 1 short, 2 overflow, 3 CRC, 4 MData, 5 DataX |
| irq | output | 1 | Endpoint interrupt |
| last_toggle | output | 2 | Recorded toggle type |
| byte_count | output | CNT_W | Bytes stored by the last accepted packet |
| rd_addr | input | ADDR_W | Bank read address |
| rd_data | output | 8 | Bank read data |

## Verification
The bench sweeps packet lengths across the bank boundary in four endpoint modes, and it varies toggle types and CRC outcomes. This catches four kinds of bad design:

- A design whose write pointer wraps would overwrite the leading bytes of an oversize packet.
- A design whose count does not saturate would report more bytes than the bank holds.
- A short-packet compare off by one would flag a packet exactly at the maximum size.
- A design that drops bad-CRC isochronous packets would miss both the data and the received flag.

It also lands a clear strobe on the same edge as a packet end, where a clear-first design loses the new flag. It sends bad-CRC bulk packets and checks that they leave the recorded toggle and count untouched.

// File: rtl/usbw_pkg.sv
package usbw_pkg;
  localparam int NFLAG = 6;
  localparam int FL_RXOUT = 0;
  localparam int FL_SHORT = 1;
  localparam int FL_OVF   = 2;
  localparam int FL_CRC   = 3;
  localparam int FL_MDATA = 4;
  localparam int FL_DATAX = 5;

  typedef enum logic [1:0] {
    TGL_DATA0 = 2'b00,
    TGL_DATA1 = 2'b01,
    TGL_DATA2 = 2'b10,
    TGL_MDATA = 2'b11
  } toggle_e;
endpackage

// File: rtl/usbw_len_track.sv
module usbw_len_track #(
  parameter int BANK_BYTES = 8,
  parameter int LEN_W      = 11,
  localparam int ADDR_W    = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_i,
  input  logic              keep_i,
  input  logic              last_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LEN_W-1:0]  len_now_o
);
  logic [LEN_W-1:0] seen_q;
  logic             at_max;
  logic             in_bank;

  assign at_max    = &seen_q;
  assign in_bank   = seen_q < LEN_W'(BANK_BYTES);
  assign len_now_o = seen_q + LEN_W'(keep_i && !at_max);
  assign wr_en_o   = beat_i && keep_i && in_bank;
  assign wr_addr_o = seen_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (beat_i) begin
      if (last_i) seen_q <= '0;
      else if (keep_i && !at_max) seen_q <= seen_q + 1'b1;
    end
  end

  // R2
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (int'(wr_addr_o) < BANK_BYTES));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && last_i) |=> (seen_q == '0));
endmodule

// File: rtl/usbw_bank_ram.sv
module usbw_bank_ram #(
  parameter int BANK_BYTES = 8,
  localparam int ADDR_W    = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [7:0] mem [BANK_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (int'(rd_addr_i) < BANK_BYTES) rd_data_o = mem[rd_addr_i];
  end
endmodule

// File: rtl/usbw_status_flags.sv
module usbw_status_flags
  import usbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic [NFLAG-1:0] en_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else if (set_i[g]) flag_q <= 1'b1;
      else if (clr_i[g]) flag_q <= 1'b0;
    end

    assign flags_o[g] = flag_q;

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i[g]) |=> flag_q);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q);
  end

  assign irq_o = |(flags_o & en_i);
endmodule

// File: rtl/usbw_out_bank_writer.sv
module usbw_out_bank_writer
  import usbw_pkg::*;
#(
  parameter int BANK_BYTES = 8,
  parameter int LEN_W      = 11,
  localparam int ADDR_W    = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_control,
  input  logic              cfg_iso,
  input  logic              cfg_hbiso,
  input  logic [LEN_W-1:0]  cfg_max_pkt,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_keep,
  input  logic              s_last,
  input  logic [1:0]        s_pid,
  input  logic              s_crc_ok,
  input  logic [5:0]        flag_en,
  input  logic [5:0]        flag_clr,
  output logic [5:0]        flags,
  output logic              irq,
  output logic [1:0]        last_toggle,
  output logic [CNT_W-1:0]  byte_count,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic             beat, commit, iso_mode, accept, too_long;
  logic             wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [LEN_W-1:0] len_now;
  logic [CNT_W-1:0] stored;
  logic [NFLAG-1:0] set_vec;
  toggle_e          toggle_q;
  logic [CNT_W-1:0] count_q;

  assign s_ready  = rst_n;
  assign beat     = s_valid && s_ready;
  assign commit   = beat && s_last;
  assign iso_mode = cfg_iso || cfg_hbiso;
  assign accept   = commit && (s_crc_ok || iso_mode);
  assign too_long = len_now > LEN_W'(BANK_BYTES);
  assign stored   = too_long ? CNT_W'(BANK_BYTES) : len_now[CNT_W-1:0];

  usbw_len_track #(.BANK_BYTES(BANK_BYTES), .LEN_W(LEN_W)) len_i (
    .clk(clk), .rst_n(rst_n), .beat_i(beat), .keep_i(s_keep), .last_i(s_last),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .len_now_o(len_now)
  );

  usbw_bank_ram #(.BANK_BYTES(BANK_BYTES)) ram_i (
    .clk(clk), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(s_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FL_RXOUT] = accept;
    set_vec[FL_SHORT] = accept && !cfg_control && (len_now < cfg_max_pkt);
    set_vec[FL_OVF]   = accept && too_long;
    set_vec[FL_CRC]   = commit && iso_mode && !s_crc_ok;
    set_vec[FL_MDATA] = accept && cfg_hbiso && (s_pid == TGL_MDATA);
    set_vec[FL_DATAX] = accept && cfg_hbiso && (s_pid != TGL_MDATA);
  end

  usbw_status_flags flags_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(flag_clr),
    .en_i(flag_en), .flags_o(flags), .irq_o(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle_q <= TGL_DATA1;
      count_q  <= '0;
    end else if (accept) begin
      toggle_q <= toggle_e'(s_pid);
      count_q  <= stored;
    end
  end

  assign last_toggle = toggle_q;
  assign byte_count  = count_q;

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(byte_count) <= BANK_BYTES);

  // R3
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && too_long) |=> (flags[FL_OVF] && flags[FL_RXOUT] &&
                              int'(byte_count) == BANK_BYTES));

  // R6
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !s_crc_ok && !iso_mode) |=> ($stable(last_toggle) && $stable(byte_count)));

  // R10
  irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && flag_en[FL_RXOUT]) |=> irq);

  // R11
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n) s_ready);
endmodule

// File: tb/usbw_out_bank_writer_tb_top.sv
module usbw_out_bank_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BANK = 8;
  localparam int LEN_W = 11;
  localparam int CNT_W = $clog2(BANK + 1);
  localparam int ADDR_W = $clog2(BANK);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_control = 0, cfg_iso = 0, cfg_hbiso = 0;
  logic [LEN_W-1:0] cfg_max_pkt = LEN_W'(BANK);
  logic s_valid = 0, s_keep = 0, s_last = 0, s_crc_ok = 0;
  logic s_ready;
  logic [7:0] s_data = 0;
  logic [1:0] s_pid = 0;
  logic [5:0] flag_en = 0, flag_clr = 0, flags;
  logic irq;
  logic [1:0] last_toggle;
  logic [CNT_W-1:0] byte_count;
  logic [ADDR_W-1:0] rd_addr = 0;
  logic [7:0] rd_data;

  int tests = 0, fails = 0;
  bit done = 0;
  int exp_tgl = 1, exp_cnt = 0;
  logic [5:0] exp_fl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbw_out_bank_writer #(.BANK_BYTES(BANK), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_control(cfg_control), .cfg_iso(cfg_iso),
    .cfg_hbiso(cfg_hbiso), .cfg_max_pkt(cfg_max_pkt), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
    .s_pid(s_pid), .s_crc_ok(s_crc_ok), .flag_en(flag_en), .flag_clr(flag_clr),
    .flags(flags), .irq(irq), .last_toggle(last_toggle), .byte_count(byte_count),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((k * 37 + i * 5 + 1) & 255);
  endfunction

  // Sends a packet; clr_on_last drives flag_clr on the final beat.
  task automatic send(input int k, input int len, input int pid, input bit crc,
                      input logic [5:0] clr_on_last);
    int nb;
    nb = (len == 0) ? 1 : len;
    for (int i = 0; i < nb; i++) begin
      s_valid = 1; s_keep = (len > 0); s_data = pat(k, i);
      s_last = (i == nb - 1); s_pid = 2'(pid); s_crc_ok = crc;
      flag_clr = s_last ? clr_on_last : 6'd0;
      #1; chk(s_ready === 1'b1, "R11", int'(s_ready), 1);
      @(negedge clk);
    end
    s_valid = 0; s_last = 0; s_keep = 0; flag_clr = 0;
  endtask

  task automatic clear_all();
    flag_clr = 6'h3F; @(negedge clk); flag_clr = 0;
  endtask

  task automatic model(input int mode, input int len, input int pid, input bit crc);
    bit iso, good;
    iso = (mode == 1 || mode == 2);
    good = crc || iso;
    exp_fl = 0;
    if (good) begin
      exp_fl[0] = 1;
      exp_fl[1] = (mode != 3) && (len < int'(cfg_max_pkt));
      exp_fl[2] = len > BANK;
      exp_fl[4] = (mode == 2) && (pid == 3);
      exp_fl[5] = (mode == 2) && (pid != 3);
      exp_tgl = pid;
      exp_cnt = (len > BANK) ? BANK : len;
    end
    exp_fl[3] = iso && !crc;
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(flags == 0, "R1 flags", int'(flags), 0);
    chk(irq == 0, "R1 irq", int'(irq), 0);
    chk(byte_count == 0, "R1 count", int'(byte_count), 0);
    chk(last_toggle == 2'b01, "R1 toggle", int'(last_toggle), 1);
    rst_n = 1;
    @(negedge clk);

    for (int mode = 0; mode < 4; mode++) begin
      cfg_iso = (mode == 1); cfg_hbiso = (mode == 2); cfg_control = (mode == 3);
      cfg_max_pkt = LEN_W'((mode == 1) ? 6 : 8);
      for (int len = 0; len <= 12; len++) begin
        int pid;
        bit crc;
        pid = (len + mode) % 4;
        crc = !((len % 4) == 2);
        flag_en = 6'(1 << (k % 6));
        send(k, len, pid, crc, 6'd0);
        model(mode, len, pid, crc);
        // R2 R3 R4 R5 R6 R7 R8 flags
        chk(flags == exp_fl, "R4/R5/R6/R8 flags", int'(flags), int'(exp_fl));
        chk(int'(byte_count) == exp_cnt, "R2/R3/R6 count", int'(byte_count), exp_cnt);
        chk(int'(last_toggle) == exp_tgl, "R7 toggle", int'(last_toggle), exp_tgl);
        // R10 irq
        chk(irq == |(exp_fl & flag_en), "R10 irq", int'(irq), int'(|(exp_fl & flag_en)));
        if (crc || mode == 1 || mode == 2) begin
          for (int a = 0; a < exp_cnt; a++) begin
            rd_addr = ADDR_W'(a); #1;
            chk(rd_data == pat(k, a), "R2 data", int'(rd_data), int'(pat(k, a)));
          end
        end
        // R9 zero write leaves flags
        repeat (2) @(negedge clk);
        chk(flags == exp_fl, "R9 hold", int'(flags), int'(exp_fl));
        clear_all();
        chk(flags == 0, "R9 clear", int'(flags), 0);
        k++;
      end
    end

    // R9 set wins over simultaneous clear
    cfg_iso = 0; cfg_hbiso = 0; cfg_control = 0; cfg_max_pkt = LEN_W'(BANK);
    send(k, 3, 0, 1, 6'h3F);
    chk(flags == 6'b000011, "R9 set wins", int'(flags), 3);
    flag_clr = 6'b000001; @(negedge clk); flag_clr = 0;
    chk(flags == 6'b000010, "R9 single clear", int'(flags), 2);
    flag_en = 0; #1;
    chk(irq == 0, "R10 irq disabled", int'(irq), 0);
    flag_en = 6'b000010; #1;
    chk(irq == 1, "R10 irq short", int'(irq), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule